// File: doc/BRIEF.md
# Multiplexed-Bus Peripheral Bridge

This block links a processor that has separate address and data buses to a peripheral that shares one set of pins for both, such as a timekeeping device with a small battery-backed register file. The whole peripheral transfer runs inside a single processor I/O cycle. In the first clock of the cycle the bridge drives the register address onto the shared bus and raises an address-latch strobe. From the next clock edge until the access ends, it switches the shared bus into a data path whose direction follows the processor's read strobe.

The peripheral's strobes come from the processor's own control lines and two chains of delay registers. The data-phase flag is the device decode delayed by one clock. The active-low data strobe is the OR of the read strobe and the inverted data-phase flag. The active-low write strobe is the OR of the processor write strobe and a copy of the data-phase flag delayed further, by as many clocks as the data setup time needs. The peripheral captures write data on the rising edge of that write strobe, so the edge cannot come earlier than the setup time after write data first appears. Removing the decode clears both delay chains at once, without waiting for a clock edge.

Top module: `mxb_bridge`

## Requirements
- R1: While reset is held, or while the device select `sel_n` is high, the bridge does not drive the shared bus (`ad_oe`=0) or the processor data bus (`cpu_rd_oe`=0). In that state `ale`=0, `ds_n`=1 and `rw_n`=1.
- R2: `cs_n` follows `sel_n` at all times, including when `iorq_n` is low and the access is meant for a different device.
- R3: From the fall of `sel_n` with `iorq_n` low until the next rising clock edge, the bridge is in the address phase: `ad_oe`=1, `ad_o`=`cpu_addr` and `ale`=1. After that edge the bridge is in the data phase and `ale`=0.
- R4: The address driver and the write-data driver are never enabled together. `ad_oe` is never 1 while `ds_n` is 0.
- R5: In the data phase with `rd_n` low, `ds_n`=0, `cpu_rd_oe`=1, `ad_oe`=0 and `cpu_rdata`=`ad_i`. `ds_n` is never 0 outside the data phase or while `rd_n` is high.
- R6: In the data phase with `rd_n` high, `ad_oe`=1 and `ad_o`=`cpu_wdata`.
- R7: With `HOLD_NS`=100 and `CLK_NS`=10, `rw_n` stays high for the first 10 rising edges of the data phase. It goes low after the 11th edge only if `wr_n` is low. Its rising edge comes at least `HOLD_NS` after the data phase starts.
- R8: When `sel_n` goes high at any point in an access, without a clock edge, all outputs return to the R1 state. The next access starts again in the address phase.
- R9: Writes and reads issued back to back through the bridge to a register-file peripheral read back the last value written to each address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iorq_n | input | 1 | Processor I/O request, active low |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| sel_n | input | 1 | Device select decode, active low |
| cpu_addr | input | BUS_W | Register address from the processor |
| cpu_wdata | input | BUS_W | Write data from the processor |
| cpu_rdata | output | BUS_W | Read data toward the processor |
| cpu_rd_oe | output | 1 | Enable for the processor-side read data driver |
| ad_o | output | BUS_W | Value the bridge drives onto the shared bus |
| ad_oe | output | 1 | Enable for the bridge's shared-bus driver |
| ad_i | input | BUS_W | Value present on the shared bus |
| ale | output | 1 | Address-latch strobe, active high |
| ds_n | output | 1 | Peripheral data strobe, active low |
| rw_n | output | 1 | Peripheral write strobe, active low; data is captured on its rising edge |
| cs_n | output | 1 | Peripheral chip select, active low |

## Verification
The assertions assume the processor follows its own bus protocol. The I/O request and device select fall together, a read and a write strobe are never low in the same access, and neither strobe falls before the first clock edge of the access. The stimulus drives every input at a falling clock edge or between edges. It lowers `rd_n` or `wr_n` only after the address phase is over, and it holds the write strobe low long enough for the delayed write enable to reach the peripheral. The deselect tests break off an access partway through, once in the read data phase and once after the write strobe has gone low.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } mxb_phase_e;

  // Number of clock periods that cover the required data setup time before
  // the write strobe may rise; never less than one.
  function automatic int unsigned strobe_delay_cycles(input int unsigned hold_ns,
                                                      input int unsigned clk_ns);
    int unsigned n;
    if (clk_ns == 0) return 1;
    n = (hold_ns + clk_ns - 1) / clk_ns;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/mxb_delay_line.sv
module mxb_delay_line #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);

  generate
    if (DEPTH <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) stage_q <= 1'b0;
        else        stage_q <= d;
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [DEPTH-1:0] chain_q;
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) chain_q <= '0;
        else        chain_q <= {chain_q[DEPTH-2:0], d};
      end
      assign q = chain_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/mxb_phase_ctrl.sv
module mxb_phase_ctrl
  import mxb_pkg::*;
#(
  parameter int unsigned WR_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iorq_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       sel_n,
  output logic       addr_en,
  output logic       wdat_en,
  output logic       rdat_en,
  output logic       ale,
  output logic       ds_n,
  output logic       rw_n,
  output logic       cs_n,
  output mxb_phase_e phase
);

  localparam int unsigned CW = $clog2(WR_CYC + 1) + 1;

  // Named internal events, brought out for the assertions.
  logic clr_n;      // both delay chains cleared while low
  logic active;     // an access to this device is in progress
  logic dphase;     // data phase: select delayed by one clock
  logic wr_ok;      // data phase delayed far enough for a write edge

  assign clr_n  = rst_n & ~sel_n;
  assign active = rst_n & ~sel_n;

  mxb_delay_line #(.DEPTH(1)) u_dphase (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (1'b1),
    .q     (dphase)
  );

  mxb_delay_line #(.DEPTH(WR_CYC)) u_wrdly (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (dphase),
    .q     (wr_ok)
  );

  assign ale     = active & ~iorq_n & ~dphase;
  assign addr_en = ale;
  assign wdat_en = active & dphase & rd_n;
  assign rdat_en = active & dphase & ~rd_n;
  assign ds_n    = rd_n | ~dphase;
  assign rw_n    = wr_n | ~wr_ok;
  assign cs_n    = sel_n;

  always_comb begin
    if (!active)     phase = PH_IDLE;
    else if (dphase) phase = PH_DATA;
    else             phase = PH_ADDR;
  end

  // Checker counter: clocks spent in the data phase, sampled synchronously.
  logic [CW-1:0] dcnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !dphase)             dcnt_q <= '0;
    else if (dcnt_q < CW'(WR_CYC))     dcnt_q <= dcnt_q + 1'b1;
  end

  // R1: no drive and no strobe while deselected
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (!addr_en && !wdat_en && !rdat_en && ds_n && rw_n && !ale));

  // R3: one clock after select the access is in its data phase
  p_dphase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |=> (sel_n || phase == PH_DATA));

  // R4: address and write-data drivers are exclusive
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_en && wdat_en));

  // R5: data strobe only for a read in the data phase
  p_ds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n |-> (!rd_n && phase == PH_DATA && rdat_en));

  // R7: write enable only after the full setup window
  p_wr_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (dcnt_q >= CW'(WR_CYC)));

  // R7: a low write strobe needs the processor write strobe
  p_rw_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> (!wr_n && phase == PH_DATA));

endmodule

// File: rtl/mxb_datapath.sv
module mxb_datapath #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             addr_en,
  input  logic             wdat_en,
  input  logic             rdat_en,
  input  logic [BUS_W-1:0] cpu_addr,
  input  logic [BUS_W-1:0] cpu_wdata,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe,
  output logic [BUS_W-1:0] cpu_rdata,
  output logic             cpu_rd_oe
);

  // Shared-bus side: address in the first phase, write data afterwards.
  assign ad_o      = addr_en ? cpu_addr : cpu_wdata;
  assign ad_oe     = addr_en | wdat_en;

  // Processor side: pass the peripheral's data back only during a read.
  assign cpu_rdata = ad_i;
  assign cpu_rd_oe = rdat_en;

endmodule

// File: rtl/mxb_bridge.sv
module mxb_bridge
  import mxb_pkg::*;
#(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned HOLD_NS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iorq_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             sel_n,
  input  logic [BUS_W-1:0] cpu_addr,
  input  logic [BUS_W-1:0] cpu_wdata,
  output logic [BUS_W-1:0] cpu_rdata,
  output logic             cpu_rd_oe,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe,
  input  logic [BUS_W-1:0] ad_i,
  output logic             ale,
  output logic             ds_n,
  output logic             rw_n,
  output logic             cs_n
);

  localparam int unsigned WR_CYC = strobe_delay_cycles(HOLD_NS, CLK_NS);

  logic       addr_en;
  logic       wdat_en;
  logic       rdat_en;
  mxb_phase_e phase;

  mxb_phase_ctrl #(.WR_CYC(WR_CYC)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .iorq_n  (iorq_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .sel_n   (sel_n),
    .addr_en (addr_en),
    .wdat_en (wdat_en),
    .rdat_en (rdat_en),
    .ale     (ale),
    .ds_n    (ds_n),
    .rw_n    (rw_n),
    .cs_n    (cs_n),
    .phase   (phase)
  );

  mxb_datapath #(.BUS_W(BUS_W)) u_dp (
    .addr_en   (addr_en),
    .wdat_en   (wdat_en),
    .rdat_en   (rdat_en),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .ad_i      (ad_i),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .cpu_rdata (cpu_rdata),
    .cpu_rd_oe (cpu_rd_oe)
  );

  // R4: bridge and peripheral never drive the shared bus together
  p_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && !ds_n));

  // R1: idle phase leaves both data paths undriven
  p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (!ad_oe && !cpu_rd_oe && cs_n == sel_n));

  // R3: the address phase presents the address with its strobe
  p_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && ad_o == cpu_addr && phase == PH_ADDR));

endmodule

// File: tb/test_mxb_bridge.sv
`timescale 1ns/1ps
module test_mxb_bridge;

  localparam int unsigned W       = 8;
  localparam int unsigned CLK_NS  = 10;
  localparam int unsigned HOLD_NS = 100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_n = 1'b1;
  logic [W-1:0] cpu_addr = '0, cpu_wdata = '0;
  logic [W-1:0] cpu_rdata, ad_o, ad_i;
  logic         cpu_rd_oe, ad_oe, ale, ds_n, rw_n, cs_n;

  int total = 0;
  int bad = 0;
  int conflicts = 0;
  bit finished = 0;
  realtime t_dstart = 0.0;
  realtime t_rise = 0.0;
  int unsigned n_exp;

  always #5 clk = ~clk;

  mxb_bridge #(.BUS_W(W), .CLK_NS(CLK_NS), .HOLD_NS(HOLD_NS)) i_mxb_bridge (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .sel_n(sel_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rd_oe(cpu_rd_oe), .ad_o(ad_o), .ad_oe(ad_oe),
    .ad_i(ad_i), .ale(ale), .ds_n(ds_n), .rw_n(rw_n), .cs_n(cs_n)
  );

  // Peripheral model: address latch plus register file.
  logic [W-1:0] regs [256];
  logic [W-1:0] lat_addr = '0;
  initial for (int i = 0; i < 256; i++) regs[i] = '0;
  always @(posedge clk) if (ale && ad_oe) lat_addr <= ad_o;
  always @(posedge rw_n) if (!cs_n || $realtime > 0) regs[lat_addr] <= ad_o;
  always @(posedge rw_n) t_rise = $realtime;
  assign ad_i = ds_n ? '0 : regs[lat_addr];

  // R4: bus conflict monitor
  always @(negedge clk) if (!ds_n && ad_oe) conflicts++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(!ad_oe && !cpu_rd_oe && !ale && ds_n && rw_n, req,
        {27'd0, ad_oe, cpu_rd_oe, ale, ds_n, rw_n}, 32'b00011);
  endtask

  task automatic do_access(input bit is_wr, input logic [W-1:0] a,
                           input logic [W-1:0] d, input logic [W-1:0] e);
    @(negedge clk);
    sel_n = 0; iorq_n = 0; rd_n = 1; wr_n = 1; cpu_addr = a; cpu_wdata = d;
    #1;
    chk(ad_oe && ale && ad_o == a, "R3 address phase", {23'd0, ad_oe, ale, ad_o},
        {23'd0, 1'b1, 1'b1, a});
    chk(cs_n == 1'b0, "R2 cs follows select", 32'(cs_n), 32'd0);
    @(posedge clk);
    t_dstart = $realtime;
    @(negedge clk);
    if (is_wr) wr_n = 0; else rd_n = 0;
    #1;
    if (is_wr) begin
      chk(ad_oe && !ale && ad_o == d, "R6 write data on bus",
          {23'd0, ad_oe, ale, ad_o}, {23'd0, 1'b1, 1'b0, d});
      chk(rw_n && ds_n, "R7 strobes high early", {30'd0, rw_n, ds_n}, 32'd3);
      repeat (n_exp - 1) @(negedge clk);
      #1 chk(rw_n == 1'b1, "R7 rw_n high through setup window", 32'(rw_n), 32'd1);
      @(negedge clk);
      #1 chk(rw_n == 1'b0, "R7 rw_n low after window", 32'(rw_n), 32'd0);
      @(negedge clk);
      wr_n = 1;
      #1;
      chk(rw_n == 1'b1, "R7 rw_n rises with wr_n", 32'(rw_n), 32'd1);
      chk((t_rise - t_dstart) >= HOLD_NS, "R7 setup time",
          32'(int'(t_rise - t_dstart)), 32'(HOLD_NS));
    end else begin
      chk(!ds_n && cpu_rd_oe && !ad_oe, "R5 read strobes",
          {29'd0, ds_n, cpu_rd_oe, ad_oe}, 32'b010);
      chk(cpu_rdata == e, "R9 read back", 32'(cpu_rdata), 32'(e));
      @(negedge clk);
      rd_n = 1;
    end
    @(negedge clk);
    sel_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1;
    #1 chk_idle("R1 idle after access");
  endtask

  // {is_write, address, write data, expected read data}
  localparam logic [24:0] VEC [10] = '{
    {1'b1, 8'h03, 8'hA5, 8'h00},
    {1'b1, 8'h1F, 8'h3C, 8'h00},
    {1'b0, 8'h03, 8'h00, 8'hA5},
    {1'b1, 8'h03, 8'h5A, 8'h00},
    {1'b0, 8'h1F, 8'h00, 8'h3C},
    {1'b0, 8'h03, 8'h00, 8'h5A},
    {1'b1, 8'h00, 8'hFF, 8'h00},
    {1'b1, 8'hFF, 8'h01, 8'h00},
    {1'b0, 8'hFF, 8'h00, 8'h01},
    {1'b0, 8'h00, 8'h00, 8'hFF}
  };

  initial begin
    // Expected write delay: smallest clock count whose span covers the setup time.
    n_exp = 0;
    while (n_exp * CLK_NS < HOLD_NS) n_exp++;
    if (n_exp == 0) n_exp = 1;

    // R1: reset holds everything idle even with select and request low.
    sel_n = 0; iorq_n = 0;
    repeat (3) @(negedge clk);
    #1 chk_idle("R1 idle during reset");
    sel_n = 1; iorq_n = 1;
    @(negedge clk);
    rst_n = 1;
    #1 chk_idle("R1 idle after reset");

    foreach (VEC[i]) begin
      do_access(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R2: I/O request for another device leaves this one alone.
    @(negedge clk);
    iorq_n = 0; cpu_addr = 8'h44;
    #1;
    chk(cs_n == 1'b1 && !ale && !ad_oe, "R2 other device",
        {30'd0, cs_n, ad_oe}, 32'b10);
    @(negedge clk); rd_n = 0;
    #1 chk_idle("R1 other device read");
    @(negedge clk); rd_n = 1; iorq_n = 1;

    // R8: deselect during a read data phase, between edges.
    @(negedge clk);
    sel_n = 0; iorq_n = 0; cpu_addr = 8'h03;
    @(negedge clk); rd_n = 0;
    @(posedge clk); #2;
    sel_n = 1;
    #1 chk_idle("R8 read aborted");
    @(negedge clk); rd_n = 1; iorq_n = 1;

    // R8: deselect after the write strobe went low, then restart.
    @(negedge clk);
    sel_n = 0; iorq_n = 0; cpu_addr = 8'h40; cpu_wdata = 8'h77;
    @(negedge clk); wr_n = 0;
    repeat (n_exp + 1) @(negedge clk);
    #1 chk(rw_n == 1'b0, "R7 rw_n low before abort", 32'(rw_n), 32'd0);
    @(posedge clk); #2;
    sel_n = 1;
    #1 chk_idle("R8 write aborted");
    @(negedge clk); wr_n = 1; iorq_n = 1;
    repeat (2) @(negedge clk);
    #1 chk_idle("R8 stays idle");
    @(negedge clk);
    sel_n = 0; iorq_n = 0; cpu_addr = 8'h21;
    #1 chk(ale && ad_oe && ad_o == 8'h21, "R8 restarts in address phase",
           {23'd0, ale, ad_oe, ad_o}, {23'd0, 1'b1, 1'b1, 8'h21});
    @(negedge clk);
    sel_n = 1; iorq_n = 1;

    // R9: value written before the abort reads back intact.
    do_access(1'b0, 8'h1F, 8'h00, 8'h3C);

    // R4: no bus conflict seen over the whole run.
    chk(conflicts == 0, "R4 no bus conflict", 32'(conflicts), 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule